// File: doc/BRIEF.md
# Four-Strike Watchdog with Paired Tick Timer

This block guards a system against software that stops making progress. A small tick timer divides a one-microsecond strobe by a programmable reload value and sends a tick to the watchdog core at each wrap. The core counts ticks down from an 8-bit period. Each time the countdown runs out, the core records one expiration and reloads the countdown. Only the fourth expiration in a row raises the system reset request, and only when reset is enabled. Before that point, software has three spare periods in which to notice the trouble, for example through the per-expiration interrupt.

Software uses a word-wide register port to program the block. Software starts the countdown with a command write. Repeating the same command while the countdown runs acts as a keepalive: it reloads the countdown and clears the expiration tally. Stopping the watchdog is deliberately awkward. The stop command has effect only when a key word was written to the key register just before it. The status register exposes the live countdown and the expiration tally together, so software can work out the time left before reset.

Top module: `expwd_top`

## Requirements
- R1: The timer register at byte address 0x10 holds the reload value in bits [29:0], the enable in bit 31 and the auto-reload select in bit 30. While enabled with a non-zero reload, the timer emits one tick for every `reload` strobes. A timer with auto-reload clear emits a single tick and then clears its own enable bit.
- R2: The configuration register at 0x00 reads back as written in these fields: timer select in bits [3:0], period in bits [11:4], interrupt enable in bit 12 and reset enable in bit 15. All other bits read as zero.
- R3: The status register at 0x04 reads the live countdown in bits [11:4] and the expiration tally in bits [13:12]. A command write with bit 0 set starts the countdown, loads it from the period field and zeroes the tally.
- R4: While the countdown runs, each tick decrements it. A tick that would bring it to zero instead reloads it from the period field and increments the tally, which wraps modulo 4. Without a tick or a command write, the countdown and the tally do not change.
- R5: The expiration that arrives while the tally is 3 raises `sys_rst_req_o`, provided reset enable is set. The request stays high until `rst_n` is asserted. With reset enable clear, the request never rises.
- R6: Each expiration produces a one-cycle pulse on `irq_o` when interrupt enable is set.
- R7: Writing bit 0 to the command register at 0x08 while the countdown runs reloads the countdown and clears the tally, which makes it a keepalive.
- R8: A command write with bit 1 set stops the countdown only if the last write before it was the value 0x0000C45A to the key register at 0x0C. Any command write clears this armed state, and so does a key write of any other value.
- R9: While the timer's enable is clear, no ticks reach the core, so the countdown and the tally stay frozen.
- R10: After reset, every register reads zero, and both `irq_o` and `sys_rst_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_strobe_i | input | 1 | One-cycle strobe per microsecond, drives the tick timer |
| wr_en_i | input | 1 | Register write enable |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | One-cycle pulse per expiration |
| sys_rst_req_o | output | 1 | Sticky system reset request |

## Verification
The embedded assertions check several properties on every cycle:
- The countdown and the tally hold still between ticks and commands.
- A stop can only follow an armed key.
- The reset request is sticky, and it can only rise on a tick while reset is enabled.
- Every interrupt pulse follows a tick that arrived with interrupts enabled.
- A start loads the period and zeroes the tally.
- A disabled timer emits no tick.

Some behaviours only the bench's scenarios can show:
- The reset fires on exactly the fourth expiration rather than an earlier one.
- A keepalive lands mid-count.
- Each way of losing the armed state leaves the countdown running.
- A one-shot timer drops its own enable after one tick.
- A frozen timer leaves the status unchanged.

The bench's reference model matches every output and the read data on every clock.

// File: rtl/expwd_pkg.sv
package expwd_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned PER_W    = 8;
    localparam int unsigned SEL_W    = 4;
    localparam int unsigned TALLY_W  = 2;
    localparam int unsigned RLD_W    = 30;

    localparam logic [ADDR_W-1:0] ADDR_CFG = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_STS = 5'h04;
    localparam logic [ADDR_W-1:0] ADDR_CMD = 5'h08;
    localparam logic [ADDR_W-1:0] ADDR_KEY = 5'h0C;
    localparam logic [ADDR_W-1:0] ADDR_TMR = 5'h10;

    localparam logic [DATA_W-1:0] KEY_WORD = 32'h0000_C45A;

    typedef struct packed {
        logic             rst_en;
        logic             irq_en;
        logic [PER_W-1:0] period;
        logic [SEL_W-1:0] sel;
    } cfg_t;
endpackage

// File: rtl/expwd_tick.sv
module expwd_tick
    import expwd_pkg::*;
#(
    parameter int unsigned RELOAD_W = RLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              tick_o,
    output logic [DATA_W-1:0] ctrl_o
);
    localparam int unsigned EN_BIT  = 31;
    localparam int unsigned PER_BIT = 30;

    typedef struct packed {
        logic                en;
        logic                periodic;
        logic [RELOAD_W-1:0] reload;
        logic [RELOAD_W-1:0] cnt;
        logic                tick;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.tick = 1'b0;
        if (wr_i) begin
            tmr_d.en       = wdata_i[EN_BIT];
            tmr_d.periodic = wdata_i[PER_BIT];
            tmr_d.reload   = wdata_i[RELOAD_W-1:0];
            tmr_d.cnt      = wdata_i[RELOAD_W-1:0];
        end else if (us_i && tmr_q.en && (tmr_q.reload != '0)) begin
            if (tmr_q.cnt <= RELOAD_W'(1)) begin
                tmr_d.tick = 1'b1;
                tmr_d.cnt  = tmr_q.reload;
                if (!tmr_q.periodic) begin
                    tmr_d.en = 1'b0;
                end
            end else begin
                tmr_d.cnt = tmr_q.cnt - RELOAD_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign tick_o = tmr_q.tick;
    always_comb begin
        ctrl_o          = DATA_W'(tmr_q.reload);
        ctrl_o[EN_BIT]  = tmr_q.en;
        ctrl_o[PER_BIT] = tmr_q.periodic;
    end

    // R1: a disabled timer never produces a tick on the following cycle
    a_r1_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_q.en |=> !tmr_q.tick);
endmodule

// File: rtl/expwd_core.sv
module expwd_core
    import expwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cfg_wr_i,
    input  logic              cmd_wr_i,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cfg_rd_o,
    output logic [DATA_W-1:0] sts_rd_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam int unsigned PER_LSB   = 4;
    localparam int unsigned IRQ_BIT   = 12;
    localparam int unsigned RST_BIT   = 15;
    localparam int unsigned TALLY_LSB = 12;
    localparam logic [TALLY_W-1:0] LAST_STRIKE = '1;

    typedef struct packed {
        cfg_t               cfg;
        logic               run;
        logic               armed;
        logic [PER_W-1:0]   count;
        logic [TALLY_W-1:0] tally;
        logic               irq;
        logic               rst_req;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d     = core_q;
        core_d.irq = 1'b0;
        if (key_wr_i) begin
            core_d.armed = (wdata_i == KEY_WORD);
        end
        if (cmd_wr_i) begin
            core_d.armed = 1'b0;
            if (wdata_i[1] && core_q.armed) begin
                core_d.run = 1'b0;
            end else if (wdata_i[0]) begin
                core_d.run   = 1'b1;
                core_d.count = core_q.cfg.period;
                core_d.tally = '0;
            end
        end else if (tick_i && core_q.run) begin
            if (core_q.count <= PER_W'(1)) begin
                core_d.count = core_q.cfg.period;
                core_d.tally = core_q.tally + TALLY_W'(1);
                core_d.irq   = core_q.cfg.irq_en;
                if ((core_q.tally == LAST_STRIKE) && core_q.cfg.rst_en) begin
                    core_d.rst_req = 1'b1;
                end
            end else begin
                core_d.count = core_q.count - PER_W'(1);
            end
        end
        if (cfg_wr_i) begin
            core_d.cfg.sel    = wdata_i[SEL_W-1:0];
            core_d.cfg.period = wdata_i[PER_LSB +: PER_W];
            core_d.cfg.irq_en = wdata_i[IRQ_BIT];
            core_d.cfg.rst_en = wdata_i[RST_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    always_comb begin
        cfg_rd_o                       = '0;
        cfg_rd_o[SEL_W-1:0]            = core_q.cfg.sel;
        cfg_rd_o[PER_LSB +: PER_W]     = core_q.cfg.period;
        cfg_rd_o[IRQ_BIT]              = core_q.cfg.irq_en;
        cfg_rd_o[RST_BIT]              = core_q.cfg.rst_en;
        sts_rd_o                       = '0;
        sts_rd_o[PER_LSB +: PER_W]     = core_q.count;
        sts_rd_o[TALLY_LSB +: TALLY_W] = core_q.tally;
    end

    assign irq_o     = core_q.irq;
    assign rst_req_o = core_q.rst_req;

    // R4: countdown and tally hold without tick or command
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cmd_wr_i) |=> ($stable(core_q.count) && $stable(core_q.tally)));
    // R8: the countdown only stops after an armed key
    a_r8_stop_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_q.run) |-> $past(core_q.armed));
    // R5: reset request is sticky
    a_r5_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.rst_req |=> core_q.rst_req);
    // R5: reset request only rises on a tick with reset enabled
    a_r5_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.rst_req) |-> ($past(tick_i) && $past(core_q.cfg.rst_en)));
    // R6: interrupt pulse follows a tick with interrupts enabled
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.irq |-> ($past(tick_i) && $past(core_q.cfg.irq_en)));
    // R3: start loads period and clears tally
    a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && wdata_i[0] && !wdata_i[1]) |=>
            ((core_q.count == $past(core_q.cfg.period)) && (core_q.tally == '0)));
endmodule

// File: rtl/expwd_top.sv
module expwd_top
    import expwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_strobe_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              sys_rst_req_o
);
    logic              tick;
    logic [DATA_W-1:0] tmr_rd, cfg_rd, sts_rd;
    logic              wr_tmr, wr_cfg, wr_cmd, wr_key;

    assign wr_tmr = wr_en_i && (addr_i == ADDR_TMR);
    assign wr_cfg = wr_en_i && (addr_i == ADDR_CFG);
    assign wr_cmd = wr_en_i && (addr_i == ADDR_CMD);
    assign wr_key = wr_en_i && (addr_i == ADDR_KEY);

    expwd_tick #(.RELOAD_W(RLD_W)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_i    (us_strobe_i),
        .wr_i    (wr_tmr),
        .wdata_i (wdata_i),
        .tick_o  (tick),
        .ctrl_o  (tmr_rd)
    );

    expwd_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .cfg_wr_i  (wr_cfg),
        .cmd_wr_i  (wr_cmd),
        .key_wr_i  (wr_key),
        .wdata_i   (wdata_i),
        .cfg_rd_o  (cfg_rd),
        .sts_rd_o  (sts_rd),
        .irq_o     (irq_o),
        .rst_req_o (sys_rst_req_o)
    );

    always_comb begin
        unique case (addr_i)
            ADDR_CFG: rdata_o = cfg_rd;
            ADDR_STS: rdata_o = sts_rd;
            ADDR_TMR: rdata_o = tmr_rd;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: tb/test_expwd_top.sv
`timescale 1ns/1ps
module test_expwd_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        us_strobe;
    logic        wr_en;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;
    logic        sys_rst;

    int n_chk = 0;
    int n_err = 0;
    int irq_cnt = 0;

    always #2.5 clk = ~clk;

    expwd_top i_expwd_top (
        .clk(clk), .rst_n(rst_n), .us_strobe_i(us_strobe), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
        .sys_rst_req_o(sys_rst)
    );

    // reference model state
    bit        m_ten, m_tper, m_tick;
    int        m_rld, m_tcnt;
    int        m_sel, m_per;
    bit        m_ie, m_re;
    bit        m_run, m_arm, m_irq, m_rst;
    int        m_cnt, m_tal;

    function automatic logic [31:0] mread(logic [4:0] a);
        case (a)
            5'h00: return 32'(m_sel) | (32'(m_per) << 4) | (32'(m_ie) << 12) | (32'(m_re) << 15);
            5'h04: return (32'(m_cnt) << 4) | (32'(m_tal) << 12);
            5'h10: return 32'(m_rld) | (32'(m_ten) << 31) | (32'(m_tper) << 30);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ten = 0; m_tper = 0; m_tick = 0; m_rld = 0; m_tcnt = 0;
            m_sel = 0; m_per = 0; m_ie = 0; m_re = 0;
            m_run = 0; m_arm = 0; m_irq = 0; m_rst = 0; m_cnt = 0; m_tal = 0;
        end else begin
            bit old_tick;
            old_tick = m_tick;
            m_irq = 0;
            if (wr_en && addr == 5'h0C) m_arm = (wdata == 32'h0000C45A);
            if (wr_en && addr == 5'h08) begin
                if (wdata[1] && m_arm) m_run = 0;
                else if (wdata[0]) begin m_run = 1; m_cnt = m_per; m_tal = 0; end
                m_arm = 0;
            end else if (old_tick && m_run) begin
                if (m_cnt <= 1) begin
                    m_cnt = m_per;
                    if (m_tal == 3 && m_re) m_rst = 1;
                    m_tal = (m_tal + 1) % 4;
                    m_irq = m_ie;
                end else m_cnt = m_cnt - 1;
            end
            if (wr_en && addr == 5'h00) begin
                m_sel = int'(wdata[3:0]); m_per = int'(wdata[11:4]);
                m_ie = wdata[12]; m_re = wdata[15];
            end
            m_tick = 0;
            if (wr_en && addr == 5'h10) begin
                m_ten = wdata[31]; m_tper = wdata[30];
                m_rld = int'(wdata[29:0]); m_tcnt = m_rld;
            end else if (us_strobe && m_ten && m_rld != 0) begin
                if (m_tcnt <= 1) begin
                    m_tick = 1; m_tcnt = m_rld;
                    if (!m_tper) m_ten = 0;
                end else m_tcnt = m_tcnt - 1;
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        n_chk++;
        if (rdata !== mread(addr)) begin
            n_err++;
            $display("FAIL R4 rdata addr=%h act=%h exp=%h", addr, rdata, mread(addr));
        end
        if (irq !== m_irq) begin
            n_err++;
            $display("FAIL R6 irq act=%b exp=%b", irq, m_irq);
        end
        if (sys_rst !== m_rst) begin
            n_err++;
            $display("FAIL R5 rst act=%b exp=%b", sys_rst, m_rst);
        end
        if (irq === 1'b1) irq_cnt++;
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1.5;
        d = rdata;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tally(int t);
        for (int i = 0; i < 500; i++) begin
            logic [31:0] s;
            @(negedge clk);
            rd(5'h04, s);
            if (int'(s[13:12]) == t) break;
        end
    endtask

    initial begin
        #(20000 * 5);
        n_err++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v, s0, s1;
        rst_n = 0; us_strobe = 0; wr_en = 0; addr = 0; wdata = 0;
        cycles(3);
        rst_n = 1;
        cycles(1);
        // R10 reset state
        rd(5'h00, v); check("R10 cfg after reset", v, 32'h0);
        rd(5'h04, v); check("R10 status after reset", v, 32'h0);
        rd(5'h10, v); check("R10 timer after reset", v, 32'h0);
        check("R10 outputs after reset", {30'h0, irq, sys_rst}, 32'h0);

        // R1 / R2 programming readback
        wr(5'h10, 32'hC000_0003);
        wr(5'h00, 32'h0000_1045);
        rd(5'h00, v); check("R2 cfg readback", v, 32'h0000_1045);
        rd(5'h10, v); check("R1 timer readback", v, 32'hC000_0003);

        // R3 start, R4 countdown, R7 keepalive
        us_strobe = 1;
        wr(5'h08, 32'h1);
        rd(5'h04, v); check("R3 status after start", v, 32'h0000_0040);
        wait_tally(2);
        us_strobe = 0;
        cycles(2);
        rd(5'h04, v); check("R4 tally reached two", {30'h0, v[13:12]}, 32'h2);
        wr(5'h08, 32'h1);
        rd(5'h04, v); check("R7 keepalive reload", v, 32'h0000_0040);

        // R6 interrupts without reset enable, R5 stays low
        irq_cnt = 0;
        us_strobe = 1;
        cycles(60);
        check("R6 irq pulses seen", 32'(irq_cnt >= 4), 32'h1);
        check("R5 no reset when disabled", {31'h0, sys_rst}, 32'h0);

        // R8 stop without key
        us_strobe = 0; cycles(2);
        rd(5'h04, s0);
        wr(5'h08, 32'h2);
        us_strobe = 1; cycles(7); us_strobe = 0; cycles(2);
        rd(5'h04, s1); check("R8 stop without key ignored", 32'(s1 != s0), 32'h1);
        // R8 wrong key
        s0 = s1;
        wr(5'h0C, 32'h0000_1234);
        wr(5'h08, 32'h2);
        us_strobe = 1; cycles(7); us_strobe = 0; cycles(2);
        rd(5'h04, s1); check("R8 stop after wrong key ignored", 32'(s1 != s0), 32'h1);
        // R8 key consumed by another command
        s0 = s1;
        wr(5'h0C, 32'h0000_C45A);
        wr(5'h08, 32'h1);
        wr(5'h08, 32'h2);
        us_strobe = 1; cycles(7); us_strobe = 0; cycles(2);
        rd(5'h04, s1); check("R8 key cleared by command", 32'(s1 != s0), 32'h1);
        // R8 proper stop
        wr(5'h0C, 32'h0000_C45A);
        wr(5'h08, 32'h2);
        cycles(2);
        rd(5'h04, s0);
        us_strobe = 1; cycles(15); us_strobe = 0; cycles(2);
        rd(5'h04, s1); check("R8 keyed stop holds status", s1, s0);

        // R9 freeze via timer enable
        us_strobe = 1;
        wr(5'h08, 32'h1);
        cycles(5);
        wr(5'h10, 32'h4000_0003);
        cycles(2);
        rd(5'h04, s0);
        cycles(20);
        rd(5'h04, s1); check("R9 frozen countdown", s1, s0);

        // R1 one-shot clears its enable
        wr(5'h10, 32'h8000_0002);
        cycles(6);
        rd(5'h10, v); check("R1 one-shot drops enable", v, 32'h0000_0002);

        // R5 fourth expiration resets
        wr(5'h10, 32'hC000_0001);
        wr(5'h00, 32'h0000_9020);
        wr(5'h08, 32'h1);
        irq_cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            #2;
            if (sys_rst) break;
        end
        check("R5 reset on fourth expiration", 32'(irq_cnt), 32'd4);
        cycles(10);
        check("R5 reset request sticky", {31'h0, sys_rst}, 32'h1);
        rst_n = 0;
        cycles(2);
        #1.5;
        check("R10 reset clears request", {30'h0, irq, sys_rst}, 32'h0);
        rst_n = 1;
        us_strobe = 0;
        cycles(2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule